// File: doc/BRIEF.md
# Streaming Pixel Colour-Space Converter

This block converts a stream of 8-bit-per-channel pixels between RGB and YCbCr using a programmable 3x3 matrix and three signed offsets. A control word selects one of three behaviours: pass-through, RGB to YCbCr, or YCbCr to RGB. Nine matrix coefficients and three offsets are loaded through six 32-bit configuration words, with two fields in each word. A plain write port sets the mode word and the coefficient words.

Pixels enter and leave on a valid/ready stream. A transfer takes place on a rising edge where both valid and ready are high. The datapath has three register stages that move together. The input is ready whenever the output stage is empty or the sink is ready. While the sink holds ready low on a valid output, the whole pipe freezes and the output word stays unchanged. Every pixel is converted with the configuration that was in force on the edge where it was accepted. A write on that same edge applies only to pixels accepted later.

The channel order on both streams is fixed. Bits [23:16] carry R or Y, bits [15:8] carry G or Cb, and bits [7:0] carry B or Cr. Matrix row 1 (A1..A3) produces the upper channel, row 2 (B1..B3) the middle channel and row 3 (C1..C3) the lower channel. Coefficient k of a row multiplies input channel k, in that same upper-to-lower order.

Top module: `pixel_csc`

## Requirements
- R1: After reset, m_valid is 0, s_ready is 1, the mode is pass-through and every coefficient and offset is 0.
- R2: Configuration word addresses and fields:
  - Address 0 holds the mode in bits [1:0].
  - Addresses 1 to 6 hold the pairs (A1,A2), (A3,B1), (B2,B3), (C1,C2), (C3,D1) and (D2,D3).
  - Matrix fields are 11 bits wide. The first field of a pair sits at [10:0] and the second at [26:16].
  - Offset fields are 9 bits wide, at [8:0] when first in the pair and at [24:16] when second.
  - All other bits, and a write to address 7, have no effect.
- R3: Mode encoding:
  - 0 is pass-through.
  - 1 is RGB to YCbCr.
  - 2 is YCbCr to RGB.
  - 3 behaves as pass-through.
  - In pass-through the output pixel equals the input pixel bit for bit.
- R4: In YCbCr to RGB mode, each output channel is its matrix row times (Y+D1, Cb+D2, Cr+D3). Coefficients are signed with 8 fraction bits. Offsets are signed integers and are always added.
- R5: In RGB to YCbCr mode, each output channel is its matrix row times (R, G, B), plus D1, D2 or D3 respectively, added after the matrix.
- R6: The full-precision sum has half an LSB added before its 8 fraction bits are dropped (arithmetic shift). The result is then saturated to the range 0..255.
- R7: With no stall, a pixel accepted on edge N is presented on m_pixel with m_valid high after edge N+2, which is three register stages. Stalls only lengthen this.
- R8: While m_valid is 1 and m_ready is 0, s_ready is 0 and m_pixel and m_valid hold their values. Otherwise s_ready is 1.
- R9: A pixel uses the mode and coefficients present before the edge on which it is accepted. A configuration write on that edge affects only later pixels.
- R10: With limited-range BT.601 YCbCr to RGB settings and a mid-grey input (Y=Cb=Cr=128), the output is the neutral grey 0x828282.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Converter can accept a pixel |
| s_pixel | input | 24 | Input pixel, three 8-bit channels |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Sink accepts the output pixel |
| m_pixel | output | 24 | Converted pixel |

## Verification
A configuration write and a pixel acceptance can fall on the same clock edge. So can a write and a stall that freezes pixels already inside the pipe. The bench provokes both by streaming pixels back to back while it rewrites the mode and coefficient words on the same edges, both in directed bursts and at random during random back-pressure. A reference model snapshots the configuration at each pixel's acceptance, before that edge's write, and judges every output against it. It also checks that frozen outputs stay bit-stable and that unstalled pixels emerge exactly three stages later.

// File: rtl/csc_pkg.sv
package csc_pkg;
  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_RGB2YCC = 2'd1,
    MODE_YCC2RGB = 2'd2,
    MODE_PASS_B  = 2'd3
  } csc_mode_e;

  localparam int NUM_CH   = 3;
  localparam int NUM_COEF = NUM_CH * NUM_CH;
endpackage

// File: rtl/csc_cfg_regs.sv
module csc_cfg_regs
  import csc_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3,
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [REG_W-1:0]                   wdata,
  output csc_mode_e                          mode,
  output logic [NUM_COEF-1:0][COEF_W-1:0]    coef,
  output logic [NUM_CH-1:0][OFS_W-1:0]       ofs
);
  localparam int HI = REG_W / 2;

  logic [COEF_W-1:0] lo_c, hi_c;
  logic [OFS_W-1:0]  lo_o, hi_o;
  logic              unused_wbits;

  assign lo_c = wdata[COEF_W-1:0];
  assign hi_c = wdata[HI+COEF_W-1:HI];
  assign lo_o = wdata[OFS_W-1:0];
  assign hi_o = wdata[HI+OFS_W-1:HI];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= MODE_PASS;
      coef <= '0;
      ofs  <= '0;
    end else if (we) begin
      case (addr)
        ADDR_W'(0): mode <= csc_mode_e'(wdata[1:0]);
        ADDR_W'(1): begin coef[0] <= lo_c; coef[1] <= hi_c; end
        ADDR_W'(2): begin coef[2] <= lo_c; coef[3] <= hi_c; end
        ADDR_W'(3): begin coef[4] <= lo_c; coef[5] <= hi_c; end
        ADDR_W'(4): begin coef[6] <= lo_c; coef[7] <= hi_c; end
        ADDR_W'(5): begin coef[8] <= lo_c; ofs[0]  <= hi_o; end
        ADDR_W'(6): begin ofs[1]  <= lo_o; ofs[2]  <= hi_o; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/csc_mult_stage.sv
module csc_mult_stage
  import csc_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9,
  parameter int PROD_W = 21
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               adv,
  input  logic                               in_valid,
  input  logic [NUM_CH*CH_W-1:0]             in_data,
  input  csc_mode_e                          mode,
  input  logic [NUM_COEF-1:0][COEF_W-1:0]    coef,
  input  logic [NUM_CH-1:0][OFS_W-1:0]       ofs,
  output logic                               out_valid,
  output logic                               out_pass,
  output logic [NUM_CH*CH_W-1:0]             out_data,
  output logic [NUM_COEF-1:0][PROD_W-1:0]    out_prod,
  output logic [NUM_CH-1:0][OFS_W-1:0]       out_post
);
  localparam int X_W = CH_W + 2;

  logic signed [X_W-1:0]    xv     [NUM_CH];
  logic signed [PROD_W-1:0] prod_c [NUM_COEF];

  // Input operands: offsets are added ahead of the matrix only for YCbCr to RGB
  for (genvar k = 0; k < NUM_CH; k++) begin : g_in
    logic signed [X_W-1:0] base;
    assign base  = $signed({2'b00, in_data[(NUM_CH-1-k)*CH_W +: CH_W]});
    assign xv[k] = (mode == MODE_YCC2RGB) ? base + X_W'($signed(ofs[k])) : base;
  end

  for (genvar r = 0; r < NUM_CH; r++) begin : g_row
    for (genvar k = 0; k < NUM_CH; k++) begin : g_col
      assign prod_c[r*NUM_CH+k] =
        PROD_W'($signed(coef[r*NUM_CH+k])) * PROD_W'(xv[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int i = 0; i < NUM_COEF; i++) out_prod[i] <= prod_c[i];
      out_data <= in_data;
      out_pass <= !(mode == MODE_RGB2YCC || mode == MODE_YCC2RGB);
      out_post <= (mode == MODE_RGB2YCC) ? ofs : '0;
    end
  end
endmodule

// File: rtl/csc_sum_stage.sv
module csc_sum_stage
  import csc_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int OFS_W  = 9,
  parameter int PROD_W = 21,
  parameter int ACC_W  = 24,
  parameter int FRAC_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               adv,
  input  logic                               in_valid,
  input  logic                               in_pass,
  input  logic [NUM_CH*CH_W-1:0]             in_data,
  input  logic [NUM_COEF-1:0][PROD_W-1:0]    in_prod,
  input  logic [NUM_CH-1:0][OFS_W-1:0]       in_post,
  output logic                               out_valid,
  output logic                               out_pass,
  output logic [NUM_CH*CH_W-1:0]             out_data,
  output logic [NUM_CH-1:0][ACC_W-1:0]       out_acc
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);

  logic signed [ACC_W-1:0] sum_c [NUM_CH];

  // Row sum, post-matrix offset (integer, so scaled by the fraction) and rounding half
  for (genvar r = 0; r < NUM_CH; r++) begin : g_row
    assign sum_c[r] = ACC_W'($signed(in_prod[r*NUM_CH]))
                    + ACC_W'($signed(in_prod[r*NUM_CH+1]))
                    + ACC_W'($signed(in_prod[r*NUM_CH+2]))
                    + (ACC_W'($signed(in_post[r])) <<< FRAC_W)
                    + HALF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int i = 0; i < NUM_CH; i++) out_acc[i] <= sum_c[i];
      out_data <= in_data;
      out_pass <= in_pass;
    end
  end
endmodule

// File: rtl/csc_sat_stage.sv
module csc_sat_stage
  import csc_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int ACC_W  = 24,
  parameter int FRAC_W = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               adv,
  input  logic                               in_valid,
  input  logic                               in_pass,
  input  logic [NUM_CH*CH_W-1:0]             in_data,
  input  logic [NUM_CH-1:0][ACC_W-1:0]       in_acc,
  output logic                               out_valid,
  output logic [NUM_CH*CH_W-1:0]             out_data
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << CH_W) - 1);

  logic [NUM_CH*CH_W-1:0] pix_c;

  for (genvar r = 0; r < NUM_CH; r++) begin : g_sat
    logic signed [ACC_W-1:0] sh;
    assign sh = $signed(in_acc[r]) >>> FRAC_W;
    assign pix_c[(NUM_CH-1-r)*CH_W +: CH_W] =
      (sh < 0) ? '0 : ((sh > MAXV) ? '1 : sh[CH_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_data <= '0;
    else if (adv) out_data <= in_pass ? in_data : pix_c;
  end
endmodule

// File: rtl/pixel_csc.sv
module pixel_csc
  import csc_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int COEF_W = 11,
  parameter int OFS_W  = 9,
  parameter int FRAC_W = 8,
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ADDR_W-1:0]         cfg_addr,
  input  logic [REG_W-1:0]          cfg_wdata,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [NUM_CH*CH_W-1:0]    s_pixel,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [NUM_CH*CH_W-1:0]    m_pixel
);
  localparam int PIX_W  = NUM_CH * CH_W;
  localparam int PROD_W = COEF_W + CH_W + 2;
  localparam int ACC_W  = PROD_W + 3;

  csc_mode_e                         mode;
  logic [NUM_COEF-1:0][COEF_W-1:0]   coef;
  logic [NUM_CH-1:0][OFS_W-1:0]      ofs;

  logic                              adv;
  logic                              v1, p1, v2, p2;
  logic [PIX_W-1:0]                  d1, d2;
  logic [NUM_COEF-1:0][PROD_W-1:0]   prod1;
  logic [NUM_CH-1:0][OFS_W-1:0]      post1;
  logic [NUM_CH-1:0][ACC_W-1:0]      acc2;

  // The whole pipe moves when the output slot is empty or being drained
  assign adv     = !m_valid || m_ready;
  assign s_ready = adv;

  csc_cfg_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .COEF_W(COEF_W), .OFS_W(OFS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .coef(coef), .ofs(ofs)
  );

  csc_mult_stage #(.CH_W(CH_W), .COEF_W(COEF_W), .OFS_W(OFS_W), .PROD_W(PROD_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(s_valid), .in_data(s_pixel),
    .mode(mode), .coef(coef), .ofs(ofs),
    .out_valid(v1), .out_pass(p1), .out_data(d1), .out_prod(prod1), .out_post(post1)
  );

  csc_sum_stage #(.CH_W(CH_W), .OFS_W(OFS_W), .PROD_W(PROD_W), .ACC_W(ACC_W),
                  .FRAC_W(FRAC_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(v1), .in_pass(p1), .in_data(d1),
    .in_prod(prod1), .in_post(post1),
    .out_valid(v2), .out_pass(p2), .out_data(d2), .out_acc(acc2)
  );

  csc_sat_stage #(.CH_W(CH_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_sat (
    .clk(clk), .rst_n(rst_n), .adv(adv), .in_valid(v2), .in_pass(p2), .in_data(d2),
    .in_acc(acc2), .out_valid(m_valid), .out_data(m_pixel)
  );
endmodule

// File: rtl/pixel_csc_checker.sv
module pixel_csc_checker #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [PIX_W-1:0] m_pixel
);
  logic [2:0] inflight;
  logic       acc, del;

  assign acc = s_valid && s_ready;
  assign del = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 3'(acc) - 3'(del);
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !m_valid);

  assert_depth_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 3'd3);

  assert_out_has_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> inflight != 3'd0);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_pixel)));

  assert_stall_blocks_input_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(inflight));
endmodule

bind pixel_csc pixel_csc_checker #(.PIX_W(24)) u_pixel_csc_checker (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_pixel(m_pixel)
);

// File: tb/pixel_csc_bench.sv
module pixel_csc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [23:0] s_pixel = '0;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [23:0] m_pixel;

  always #2 clk = ~clk;

  pixel_csc u_pixel_csc (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_pixel(s_pixel),
    .m_valid(m_valid), .m_ready(m_ready), .m_pixel(m_pixel)
  );

  int checks = 0, failures = 0, cyc = 0, stall_cnt = 0;
  int cf [9];
  int of [3];
  int mode_b = 0;

  logic        n_we = 0, n_sv = 0, n_mr = 1;
  logic [2:0]  n_addr = 0;
  logic [31:0] n_wdata = 0;
  logic [23:0] n_px = 0;
  logic        n_force = 0;
  logic [23:0] n_force_val = 0;
  logic        prev_stall = 0;
  logic [23:0] prev_px = 0;

  logic [23:0] exp_q [$];
  int          cyc_q [$];
  int          stl_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int sx(input int v, input int w);
    return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
  endfunction

  // Reference from R3..R6
  function automatic logic [23:0] model(input logic [23:0] px);
    int in [3];
    logic [23:0] r;
    if (mode_b != 1 && mode_b != 2) return px;
    in[0] = int'(px[23:16]); in[1] = int'(px[15:8]); in[2] = int'(px[7:0]);
    r = '0;
    for (int row = 0; row < 3; row++) begin
      int s, v;
      s = 0;
      for (int k = 0; k < 3; k++)
        s += sx(cf[row*3+k], 11) * (in[k] + ((mode_b == 2) ? sx(of[k], 9) : 0));
      if (mode_b == 1) s += sx(of[row], 9) * 256;
      v = (s + 128) >>> 8;
      if (v < 0) v = 0;
      if (v > 255) v = 255;
      r[(2-row)*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  // R2 decode kept by the bench
  task automatic apply_cfg(input logic [2:0] a, input logic [31:0] d);
    case (a)
      3'd0: mode_b = int'(d[1:0]);
      3'd1: begin cf[0] = int'(d[10:0]); cf[1] = int'(d[26:16]); end
      3'd2: begin cf[2] = int'(d[10:0]); cf[3] = int'(d[26:16]); end
      3'd3: begin cf[4] = int'(d[10:0]); cf[5] = int'(d[26:16]); end
      3'd4: begin cf[6] = int'(d[10:0]); cf[7] = int'(d[26:16]); end
      3'd5: begin cf[8] = int'(d[10:0]); of[0] = int'(d[24:16]); end
      3'd6: begin of[1] = int'(d[8:0]);  of[2] = int'(d[24:16]); end
      default: ;
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
    cfg_we = n_we; cfg_addr = n_addr; cfg_wdata = n_wdata;
    s_valid = n_sv; s_pixel = n_px; m_ready = n_mr;
    #1;
    if (m_valid && !m_ready) begin
      stall_cnt++;
      chk(!s_ready, "R8 ready low in stall", 32'(s_ready), 32'd0);
      if (prev_stall) chk(m_pixel == prev_px, "R8 hold", 32'(m_pixel), 32'(prev_px));
    end else if (rst_n) begin
      chk(s_ready, "R8 ready high", 32'(s_ready), 32'd1);
    end
    prev_stall = m_valid && !m_ready;
    prev_px = m_pixel;
    if (m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected output", 32'(m_pixel), 32'd0);
      end else begin
        logic [23:0] e;
        int c0, s0;
        e = exp_q.pop_front(); c0 = cyc_q.pop_front(); s0 = stl_q.pop_front();
        chk(m_pixel == e, "R4/R5/R6/R9 data", 32'(m_pixel), 32'(e));
        if (s0 == stall_cnt) chk(cyc - c0 == 3, "R7 latency", 32'(cyc - c0), 32'd3);
        else chk(cyc - c0 >= 3, "R7 latency stalled", 32'(cyc - c0), 32'd3);
      end
    end
    if (s_valid && s_ready) begin
      exp_q.push_back(n_force ? n_force_val : model(s_pixel));
      cyc_q.push_back(cyc);
      stl_q.push_back(stall_cnt);
    end
    if (cfg_we) apply_cfg(cfg_addr, cfg_wdata);
    n_we = 0; n_force = 0;
    cyc++;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    n_we = 1; n_addr = a; n_wdata = d; n_sv = 0;
    tick();
  endtask

  function automatic logic [31:0] pk(input int lo, input int hi);
    return {5'h1f, 11'(hi), 5'h1f, 11'(lo)};
  endfunction

  task automatic send(input logic [23:0] px);
    n_sv = 1; n_px = px; n_mr = 1;
    tick();
    n_sv = 0;
  endtask

  task automatic drain();
    n_sv = 0; n_mr = 1;
    for (int i = 0; i < 12; i++) tick();
    chk(exp_q.size() == 0, "R7 drained", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic load_ycc601();
    wr(3'd1, pk('h12a, 'h000)); wr(3'd2, pk('h199, 'h12a));
    wr(3'd3, pk('h79c, 'h730)); wr(3'd4, pk('h12a, 'h204));
    wr(3'd5, {7'h7f, 9'h1f0, 5'h1f, 11'h000});
    wr(3'd6, {7'h7f, 9'h180, 7'h7f, 9'h180});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 9; i++) cf[i] = 0;
    for (int i = 0; i < 3; i++) of[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!m_valid, "R1 m_valid after reset", 32'(m_valid), 32'd0);
    chk(s_ready, "R1 s_ready after reset", 32'(s_ready), 32'd1);
    // R1/R3 reset mode passes pixels unchanged
    n_force = 1; n_force_val = 24'h12ab9f; send(24'h12ab9f);
    send(24'h00ff80);
    drain();

    // R10 and R4: limited BT.601 YCbCr to RGB, mid grey
    load_ycc601();
    wr(3'd0, 32'hfffffffe);  // mode 2, upper bits ignored (R2)
    n_force = 1; n_force_val = 24'h828282; send(24'h808080);
    // R6: black below zero clamps, bright red saturates
    n_force = 1; n_force_val = 24'h000000; send(24'h008080);
    send(24'hff80ff);
    send(24'h51f05a);
    drain();

    // R5: BT.601 limited RGB to YCbCr, offsets after the matrix
    wr(3'd1, pk('h041, 'h081)); wr(3'd2, pk('h019, 'h7db));
    wr(3'd3, pk('h7b6, 'h070)); wr(3'd4, pk('h070, 'h7a2));
    wr(3'd5, {7'h00, 9'h010, 5'h00, 11'h7ee});
    wr(3'd6, {7'h00, 9'h080, 7'h00, 9'h080});
    wr(3'd7, 32'hffffffff);  // R2 no effect
    wr(3'd0, 32'd1);
    n_force = 1; n_force_val = 24'h108080; send(24'h000000);
    send(24'hffffff); send(24'hff0000); send(24'h00ff00);
    drain();

    // R3: mode 3 passes through
    wr(3'd0, 32'd3);
    n_force = 1; n_force_val = 24'h3c4d5e; send(24'h3c4d5e);
    drain();

    // R9: write on the same edge as acceptance, back to back
    for (int i = 0; i < 16; i++) begin
      n_we = 1; n_addr = 3'd0; n_wdata = 32'(i % 3);
      n_sv = 1; n_px = 24'(32'h203040 + i * 32'h050709); n_mr = 1;
      tick();
    end
    n_sv = 0;
    drain();

    // Random traffic with back-pressure and concurrent writes (R2..R9)
    begin
      logic holding;
      holding = 0;
      for (int i = 0; i < 6000; i++) begin
        if (!holding || ($urandom % 8) == 0) begin
          n_sv = ($urandom % 4) != 0;
          n_px = 24'($urandom);
        end
        n_mr = ($urandom % 3) != 0;
        if (($urandom % 10) == 0) begin
          n_we = 1; n_addr = 3'($urandom); n_wdata = $urandom;
          if (($urandom % 2) == 0) begin n_addr = 3'd0; n_wdata = 32'($urandom % 4); end
        end
        tick();
        holding = s_valid && !s_ready;
      end
    end
    drain();

    summary();
    $finish;
  end
endmodule